// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block combines every reset cause of a small controller into a single active-high internal reset for the processor and its peripherals. The causes are the power-up event, the bidirectional reset pin, a watchdog timeout, a low-supply detect and an access to an unmapped address. After power-up the block waits until the oscillator reports that it is running. It then counts a fixed start-up interval before it lets the internal reset go. If the pin is still held low at that point, the reset is stretched until the pin is seen high.

The pin level is brought into the clock domain through a flop chain. A low level only counts as an external reset once it has been seen on two consecutive samples, so a single-cycle dip is ignored. The three fault requests drive an open-drain pulldown on the pin, which warns other devices on the board. The pulldown lasts at least a minimum window, or for as long as the request lasts if that is longer. It never starts while something outside already holds the pin low. The pin reads back low while the block is pulling it down. That readback is masked so that it is never taken for an external reset.

A status/control byte holds two software-visible bits. One is a power-up flag that hardware sets and software can only clear. The other is a read/write watchdog enable. A three-bit cause code records what started the most recent reset.

Top module: `rstseq_top`

## Requirements
- R1: While `por_ni` is low, and afterwards until `osc_ok_i` has been high for STARTUP_CYC (default 4064) rising edges, `sys_rst_o` is 1. With no other cause active, `sys_rst_o` reads 1 in the cycle of the STARTUP_CYC-th counted edge and 0 from the next edge on.
- R2: If the synchronized pin is low when the start-up interval ends, `sys_rst_o` stays 1 until the pin has been seen high. It falls 4 edges after the pin rises.
- R3: An external reset is recognized after two consecutive low samples of the synchronized pin. `sys_rst_o` rises 4 cycles after the pin falls (2 synchronizer stages plus 2 qualifying samples). A low pulse of one cycle has no effect on `sys_rst_o` or `cause_o`.
- R4: `wdog_req_i`, `lvd_req_i` or `ill_req_i` drives `sys_rst_o` to 1 in the same cycle. The reset is held until every request and the pulldown have ended, and falls one edge later.
- R5: Any of the three fault requests sets `pin_pd_o` on the next edge. A power-up never sets `pin_pd_o`.
- R6: `pin_pd_o` stays 1 for at least PD_MIN (default 4) cycles. If a request lasts longer, `pin_pd_o` drops on the first edge that sees the request low.
- R7: A fault request that arrives while the synchronized pin is low and the block is not pulling it down leaves `pin_pd_o` at 0.
- R8: The pin readback during the block's own pulldown, and during the synchronizer delay after it, is never treated as an external reset.
- R9: `csr_rdata_o` bit 0 is the power-up flag: it is 1 after every power-up, a write with `csr_wdata_i[0]`=0 clears it, and a write with 1 leaves it unchanged. Bit 1 is a watchdog enable that is written from `csr_wdata_i[1]`. Bits 7:2 read 0. A write takes effect on the next edge and is ignored while `sys_rst_o` is 1.
- R10: A reset whose recorded cause is not power-up clears bits 0 and 1 of `csr_rdata_o` one edge after the cause is recorded.
- R11: `cause_o` is 0 after power-up. When a reset starts from the released state, the cause is captured on the next edge in priority order: low-voltage 1, watchdog 2, illegal address 3, external pin 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| por_ni | input | 1 | Power-up reset, active low, asynchronous |
| osc_ok_i | input | 1 | Oscillator running indication |
| pin_lvl_i | input | 1 | Raw level of the bidirectional reset pin |
| wdog_req_i | input | 1 | Watchdog timeout request |
| lvd_req_i | input | 1 | Low-supply detect request |
| ill_req_i | input | 1 | Unmapped-address access request |
| csr_wr_i | input | 1 | Write strobe for the status/control byte |
| csr_wdata_i | input | 2 | Write data: bit 0 flag, bit 1 watchdog enable |
| sys_rst_o | output | 1 | Internal reset, active high |
| pin_pd_o | output | 1 | Enable of the open-drain pin pulldown |
| csr_rdata_o | output | 8 | Status/control byte read value |
| cause_o | output | 3 | Code of the most recent reset cause |

## Verification
Each result has a fixed distance from its stimulus:
- A fault request shows on `sys_rst_o` in its own cycle, on `pin_pd_o` and `cause_o` one edge later, and as a cleared byte two edges later.
- An external pin edge reaches `sys_rst_o` four edges later in each direction. The falling case is two synchronizer stages plus two qualifying samples. The rising case adds one edge for the registered release.
- The start-up release lands 4065 edges after the oscillator becomes valid.

The driver works out the due cycle of each expected value when it applies the stimulus and queues them in due order. The monitor compares them at the falling clock edge of exactly that cycle. Windows that must stay quiet, such as after a glitch or after the pulldown, are covered by several entries spread across the window.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [2:0] {
        CAUSE_POR  = 3'd0,
        CAUSE_LVD  = 3'd1,
        CAUSE_WDOG = 3'd2,
        CAUSE_ILL  = 3'd3,
        CAUSE_EXT  = 3'd4
    } cause_e;

    localparam int CSR_FLAG_BIT = 0;
    localparam int CSR_WDEN_BIT = 1;
    localparam int CSR_WIDTH    = 8;

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sh_q <= {STAGES{RST_VAL}};
        end else begin
            sh_q <= sh_d;
        end
    end

    assign q_o = sh_q[STAGES-1];

endmodule

// File: rtl/rstseq_startup.sv
module rstseq_startup #(
    parameter int CYCLES = 4064
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic osc_ok_i,
    output logic done_o
);

    localparam int CW = $clog2(CYCLES + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.done && osc_ok_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == CW'(CYCLES - 1)) begin
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o = st_q.done;

    // R1: once the interval has elapsed it stays elapsed until power-up
    a_r1_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.done |=> st_q.done);

    // R1: the interval only completes on a cycle with the oscillator valid
    a_r1_done_needs_osc: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(st_q.done) |-> $past(osc_ok_i));

endmodule

// File: rtl/rstseq_pulldown.sv
module rstseq_pulldown #(
    parameter int PD_MIN   = 4,
    parameter int MASK_CYC = 3
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_i,
    input  logic ext_busy_i,
    output logic pd_o,
    output logic mask_o
);

    localparam int WW = $clog2(PD_MIN + 1);
    localparam int MW = $clog2(MASK_CYC + 1);

    typedef struct packed {
        logic          on;
        logic [WW-1:0] win;
        logic [MW-1:0] hold;
    } pd_t;

    pd_t pd_d, pd_q;

    always_comb begin
        pd_d = pd_q;
        if (!pd_q.on) begin
            if (req_i && !ext_busy_i) begin
                pd_d.on  = 1'b1;
                pd_d.win = WW'(PD_MIN - 1);
            end
        end else if (pd_q.win != '0) begin
            pd_d.win = pd_q.win - 1'b1;
        end else if (!req_i) begin
            pd_d.on = 1'b0;
        end

        if (pd_q.on) begin
            pd_d.hold = MW'(MASK_CYC);
        end else if (pd_q.hold != '0) begin
            pd_d.hold = pd_q.hold - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pd_q <= '0;
        end else begin
            pd_q <= pd_d;
        end
    end

    assign pd_o   = pd_q.on;
    assign mask_o = pd_q.on | (pd_q.hold != '0);

    // R7: no pulldown starts while the pin is held low from outside
    a_r7_suppress: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pd_q.on && ext_busy_i) |=> !pd_q.on);

    // R6: pulldown persists while a request persists
    a_r6_hold_with_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pd_q.on && req_i) |=> pd_q.on);

    generate
        if (PD_MIN >= 4) begin : g_minw
            // R6: a pulldown that ends has been on for at least four cycles
            a_r6_min_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
                $fell(pd_q.on) |-> ($past(pd_q.on, 2) && $past(pd_q.on, 3) && $past(pd_q.on, 4)));
        end
    endgenerate

endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int STARTUP_CYC = 4064,
    parameter int SYNC_STAGES = 2,
    parameter int QUAL_CYC    = 2,
    parameter int PD_MIN      = 4
) (
    input  logic       clk_i,
    input  logic       por_ni,
    input  logic       osc_ok_i,
    input  logic       pin_lvl_i,
    input  logic       wdog_req_i,
    input  logic       lvd_req_i,
    input  logic       ill_req_i,
    input  logic       csr_wr_i,
    input  logic [1:0] csr_wdata_i,
    output logic       sys_rst_o,
    output logic       pin_pd_o,
    output logic [7:0] csr_rdata_o,
    output logic [2:0] cause_o
);

    localparam int QW       = $clog2(QUAL_CYC + 1);
    localparam int MASK_CYC = SYNC_STAGES + 1;

    typedef struct packed {
        logic          rst;
        logic [QW-1:0] lowcnt;
        logic          flag;
        logic          wden;
        cause_e        cause;
    } seq_t;

    seq_t seq_d, seq_q;

    logic pin_s;
    logic st_done;
    logic pd_on;
    logic pd_mask;
    logic req_any;
    logic ext_busy;
    logic ext_act;

    rstseq_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (por_ni),
        .d_i    (pin_lvl_i),
        .q_o    (pin_s)
    );

    rstseq_startup #(
        .CYCLES (STARTUP_CYC)
    ) u_startup (
        .clk_i    (clk_i),
        .rst_ni   (por_ni),
        .osc_ok_i (osc_ok_i),
        .done_o   (st_done)
    );

    rstseq_pulldown #(
        .PD_MIN   (PD_MIN),
        .MASK_CYC (MASK_CYC)
    ) u_pulldown (
        .clk_i      (clk_i),
        .rst_ni     (por_ni),
        .req_i      (req_any),
        .ext_busy_i (ext_busy),
        .pd_o       (pd_on),
        .mask_o     (pd_mask)
    );

    assign req_any  = wdog_req_i | lvd_req_i | ill_req_i;
    assign ext_busy = !pin_s && !pd_mask;
    assign ext_act  = (seq_q.lowcnt == QW'(QUAL_CYC));

    always_comb begin
        seq_d = seq_q;

        // qualification of the external level
        if (ext_busy) begin
            if (!ext_act) begin
                seq_d.lowcnt = seq_q.lowcnt + 1'b1;
            end
        end else begin
            seq_d.lowcnt = '0;
        end

        // release only when every hold condition is gone
        seq_d.rst = !(st_done && !ext_act && !pd_on && !req_any);

        // cause capture on entry into reset
        if (!seq_q.rst) begin
            if (lvd_req_i) begin
                seq_d.cause = CAUSE_LVD;
            end else if (wdog_req_i) begin
                seq_d.cause = CAUSE_WDOG;
            end else if (ill_req_i) begin
                seq_d.cause = CAUSE_ILL;
            end else if (ext_act) begin
                seq_d.cause = CAUSE_EXT;
            end
        end

        // status/control byte
        if (seq_q.rst && (seq_q.cause != CAUSE_POR)) begin
            seq_d.flag = 1'b0;
            seq_d.wden = 1'b0;
        end else if (csr_wr_i && !sys_rst_o) begin
            seq_d.flag = seq_q.flag & csr_wdata_i[CSR_FLAG_BIT];
            seq_d.wden = csr_wdata_i[CSR_WDEN_BIT];
        end
    end

    always_ff @(posedge clk_i or negedge por_ni) begin
        if (!por_ni) begin
            seq_q <= '{rst: 1'b1, lowcnt: '0, flag: 1'b1, wden: 1'b0, cause: CAUSE_POR};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign sys_rst_o = seq_q.rst | req_any | ext_act;
    assign pin_pd_o  = pd_on;
    assign cause_o   = seq_q.cause;

    always_comb begin
        csr_rdata_o               = '0;
        csr_rdata_o[CSR_FLAG_BIT] = seq_q.flag;
        csr_rdata_o[CSR_WDEN_BIT] = seq_q.wden;
    end

    // R1: no release before the start-up interval has elapsed
    a_r1_hold_until_startup: assert property (@(posedge clk_i) disable iff (!por_ni)
        !st_done |-> sys_rst_o);

    // R2: a qualified external level always keeps the reset on
    a_r2_ext_holds: assert property (@(posedge clk_i) disable iff (!por_ni)
        ext_act |-> sys_rst_o);

    // R4: release only follows a cycle with no request, no pulldown, no pin reset
    a_r4_release_clean: assert property (@(posedge clk_i) disable iff (!por_ni)
        $fell(seq_q.rst) |-> $past(!req_any && !pd_on && !ext_act));

    // R9: software can never make the power-up flag rise
    a_r9_flag_no_set: assert property (@(posedge clk_i) disable iff (!por_ni)
        !$rose(seq_q.flag));

endmodule

// File: tb/rstseq_top_tb_top.sv
module rstseq_top_tb_top;

    typedef struct {
        int         due;
        int         fld;
        logic [7:0] exp;
        string      tag;
    } item_t;

    localparam int F_RST   = 0;
    localparam int F_PD    = 1;
    localparam int F_CSR   = 2;
    localparam int F_CAUSE = 3;
    localparam int LIMIT   = 50000;

    logic       clk = 1'b0;
    logic       por_n;
    logic       osc_ok;
    logic       ext_low;
    logic       pin_lvl;
    logic       wdog, lvd, ill;
    logic       csr_wr;
    logic [1:0] csr_wd;
    logic       sys_rst, pin_pd;
    logic [7:0] csr_rd;
    logic [2:0] cause;

    int    cyc    = 0;
    int    nchk   = 0;
    int    nfail  = 0;
    bit    done   = 1'b0;
    item_t sbq[$];

    always #5 clk = ~clk;

    // open-drain pin: low when driven from outside or pulled down by the block
    assign pin_lvl = !(ext_low || pin_pd);

    rstseq_top dut_i (
        .clk_i       (clk),
        .por_ni      (por_n),
        .osc_ok_i    (osc_ok),
        .pin_lvl_i   (pin_lvl),
        .wdog_req_i  (wdog),
        .lvd_req_i   (lvd),
        .ill_req_i   (ill),
        .csr_wr_i    (csr_wr),
        .csr_wdata_i (csr_wd),
        .sys_rst_o   (sys_rst),
        .pin_pd_o    (pin_pd),
        .csr_rdata_o (csr_rd),
        .cause_o     (cause)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic expect_at(input int due, input int fld, input logic [7:0] v, input string tag);
        item_t it;
        it.due = due;
        it.fld = fld;
        it.exp = v;
        it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    // monitor: compares each queued item in its due cycle, away from the edge
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            item_t      it;
            logic [7:0] act;
            it = sbq.pop_front();
            case (it.fld)
                F_RST:   act = {7'b0, sys_rst};
                F_PD:    act = {7'b0, pin_pd};
                F_CSR:   act = csr_rd;
                default: act = {5'b0, cause};
            endcase
            nchk++;
            if (act !== it.exp) begin
                nfail++;
                $display("FAIL %s cycle %0d field %0d: actual %0h expected %0h",
                         it.tag, cyc, it.fld, act, it.exp);
            end
        end
    end

    always @(posedge clk) begin
        if (!done && cyc > LIMIT) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, LIMIT);
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int t;
        por_n   = 1'b0;
        osc_ok  = 1'b0;
        ext_low = 1'b0;
        wdog    = 1'b0;
        lvd     = 1'b0;
        ill     = 1'b0;
        csr_wr  = 1'b0;
        csr_wd  = 2'b00;
        step(3);

        // reset state
        t = cyc;
        expect_at(t, F_RST,   8'h01, "R1 reset state");
        expect_at(t, F_PD,    8'h00, "R5 reset state");
        expect_at(t, F_CSR,   8'h01, "R9 reset state");
        expect_at(t, F_CAUSE, 8'h00, "R11 reset state");
        step(2);

        // released from power-up but oscillator not yet valid
        por_n = 1'b1;
        t = cyc;
        expect_at(t + 20, F_RST, 8'h01, "R1 oscillator not valid");
        step(25);

        // start-up interval
        osc_ok = 1'b1;
        t = cyc;
        expect_at(t + 4064, F_RST, 8'h01, "R1 last held cycle");
        expect_at(t + 4065, F_RST, 8'h00, "R1 release");
        step(4070);

        // status/control byte writes
        t = cyc;
        csr_wr = 1'b1; csr_wd = 2'b11;
        expect_at(t + 1, F_CSR, 8'h03, "R9 enable set, flag kept");
        step(1); csr_wr = 1'b0; step(3);
        t = cyc;
        csr_wr = 1'b1; csr_wd = 2'b10;
        expect_at(t + 1, F_CSR, 8'h02, "R9 flag cleared by 0");
        step(1); csr_wr = 1'b0; step(3);
        t = cyc;
        csr_wr = 1'b1; csr_wd = 2'b11;
        expect_at(t + 1, F_CSR, 8'h02, "R9 flag write of 1 ignored");
        step(1); csr_wr = 1'b0; step(3);

        // single-cycle watchdog request
        t = cyc;
        wdog = 1'b1;
        expect_at(t,      F_RST,   8'h01, "R4 same-cycle reset");
        expect_at(t + 1,  F_PD,    8'h01, "R5 pulldown on");
        expect_at(t + 1,  F_CAUSE, 8'h02, "R11 watchdog code");
        expect_at(t + 2,  F_CSR,   8'h00, "R10 byte cleared");
        expect_at(t + 4,  F_PD,    8'h01, "R6 minimum window");
        expect_at(t + 5,  F_PD,    8'h00, "R6 window end");
        expect_at(t + 5,  F_RST,   8'h01, "R4 held with pulldown");
        expect_at(t + 6,  F_RST,   8'h00, "R4 release");
        expect_at(t + 8,  F_RST,   8'h00, "R8 readback ignored");
        expect_at(t + 12, F_RST,   8'h00, "R8 readback ignored late");
        expect_at(t + 12, F_CAUSE, 8'h02, "R8 cause not external");
        step(1); wdog = 1'b0; step(20);

        // long low-voltage request
        t = cyc;
        lvd = 1'b1;
        expect_at(t + 1,  F_CAUSE, 8'h01, "R11 low-voltage code");
        expect_at(t + 1,  F_PD,    8'h01, "R5 pulldown on lvd");
        expect_at(t + 10, F_PD,    8'h01, "R6 held with request");
        expect_at(t + 11, F_PD,    8'h00, "R6 drop after request");
        expect_at(t + 11, F_RST,   8'h01, "R4 held");
        expect_at(t + 12, F_RST,   8'h00, "R4 release after lvd");
        step(10); lvd = 1'b0; step(20);

        // priority between simultaneous requests
        t = cyc;
        wdog = 1'b1; ill = 1'b1;
        expect_at(t + 1, F_CAUSE, 8'h02, "R11 watchdog over illegal");
        step(1); wdog = 1'b0; ill = 1'b0; step(20);
        t = cyc;
        ill = 1'b1;
        expect_at(t + 1, F_CAUSE, 8'h03, "R11 illegal code");
        expect_at(t + 1, F_PD,    8'h01, "R5 pulldown on illegal");
        step(1); ill = 1'b0; step(20);
        t = cyc;
        lvd = 1'b1; wdog = 1'b1; ill = 1'b1;
        expect_at(t + 1, F_CAUSE, 8'h01, "R11 low-voltage first");
        step(1); lvd = 1'b0; wdog = 1'b0; ill = 1'b0; step(20);

        // one-cycle glitch on the pin
        t = cyc;
        ext_low = 1'b1;
        expect_at(t + 2, F_RST,   8'h00, "R3 glitch");
        expect_at(t + 4, F_RST,   8'h00, "R3 glitch");
        expect_at(t + 6, F_RST,   8'h00, "R3 glitch");
        expect_at(t + 6, F_CAUSE, 8'h01, "R3 glitch cause kept");
        step(1); ext_low = 1'b0; step(20);

        // qualified external reset
        t = cyc;
        ext_low = 1'b1;
        expect_at(t + 3,  F_RST,   8'h00, "R3 not yet qualified");
        expect_at(t + 4,  F_RST,   8'h01, "R3 qualified");
        expect_at(t + 5,  F_CAUSE, 8'h04, "R11 external code");
        expect_at(t + 6,  F_PD,    8'h00, "R5 no pulldown for pin");
        expect_at(t + 11, F_RST,   8'h01, "R3 held until pin seen high");
        expect_at(t + 12, F_RST,   8'h00, "R3 release");
        step(8); ext_low = 1'b0; step(20);

        // fault during an external reset: pulldown suppressed
        t = cyc;
        ext_low = 1'b1;
        expect_at(t + 6, F_RST, 8'h01, "R7 reset on");
        expect_at(t + 7, F_PD,  8'h00, "R7 suppressed");
        expect_at(t + 9, F_PD,  8'h00, "R7 still suppressed");
        step(6); wdog = 1'b1; step(1); wdog = 1'b0;
        step(5); ext_low = 1'b0; step(20);

        // second power-up with the pin held low past the start-up interval
        t = cyc;
        por_n = 1'b0; ext_low = 1'b1;
        expect_at(t, F_CSR,   8'h01, "R9 flag set on power-up");
        expect_at(t, F_CAUSE, 8'h00, "R11 power-up code");
        step(3);
        por_n = 1'b1;
        t = cyc;
        expect_at(t + 10,   F_PD,  8'h00, "R5 no pulldown at power-up");
        expect_at(t + 4064, F_RST, 8'h01, "R2 held past interval");
        expect_at(t + 4090, F_RST, 8'h01, "R2 still held");
        step(4100);
        ext_low = 1'b0;
        t = cyc;
        expect_at(t + 3, F_RST,   8'h01, "R2 last held cycle");
        expect_at(t + 4, F_RST,   8'h00, "R2 release after pin high");
        expect_at(t + 4, F_CAUSE, 8'h00, "R11 power-up code kept");
        expect_at(t + 4, F_CSR,   8'h01, "R9 flag kept");
        step(10);

        while (sbq.size() > 0) step(1);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule